// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Incrementer Groups

This block is a purely combinational binary adder. It adds two unsigned operands and a single carry-in bit, and it returns the sum and a carry-out. The operand width is a parameter and may be 16, 32, 64 or 128 bits. The bits are divided into groups, and the group sizes grow toward the most significant end. Because of this, the carry that selects each group's result arrives at about the same time as the group's own local result.

The lowest group is a plain ripple-carry adder, and it consumes the external carry-in. Each higher group computes its slice once, using a ripple-carry adder that assumes no incoming carry. The group does not duplicate that adder for the carry-one case. Instead, an incrementer adds one to the zero-carry result, including its carry bit. A two-way selector in each group takes the carry produced by the group below and chooses between the zero-carry result and the incremented result. The block holds no state, so it needs no clock and no reset.

Top module: `csel_sqrt_adder`

## Requirements
- R1: For every input, the concatenation {carry_out, sum_out} equals op_a + op_b + carry_in, computed at WIDTH+1 bits.
- R2: Group sizes from bit 0 upward are 2, 2, 3, 4, 5 and so on, with each later group one bit larger than the one before. The final group is trimmed so that the sizes add up to exactly WIDTH. A carry that ripples up to any bit position, including each group boundary, yields the correct sum.
- R3: The lowest group (bits 1:0) is the only group that sees carry_in, and its carry-out matches the carry of op_a[1:0] + op_b[1:0] + carry_in.
- R4: When the carry arriving at a higher group is 0, that group's sum bits equal the low bits of the plain sum of its operand slices.
- R5: When the carry arriving at a higher group is 1, that group's sum bits equal the plain sum of its operand slices plus one, truncated to the slice width.
- R6: The incrementer spans the group's sum bits plus its zero-carry carry-out. As a result, each group's carry-out equals the true carry out of bit position (group top) for the full addition.
- R7: carry_out is the carry selected for the most significant group. All ones plus a carry-in of 1 gives carry_out = 1 and sum_out = 0.
- R8: The same code builds correct adders for WIDTH of 16, 32, 64 and 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds four copies side by side, at WIDTH 16, 32, 64 and 128, and drives all of them from shared 128-bit stimulus. These four widths cover the untrimmed five-group split and three different trimmed top groups, with sizes of 3, 8 and 7 bits. A sweep of carry chains that run from bit 0 up to every position makes the carry stop at every group boundary of every width. All-ones patterns, alternating-bit patterns and random vectors then exercise both selector paths and the carry out of the incrementer.

// File: rtl/csel_sqrt_pkg.sv
`timescale 1ns/1ps
package csel_sqrt_pkg;

    localparam int MAX_GROUPS = 32;

    // Untrimmed size of group k: 2, 2, 3, 4, 5, ...
    function automatic int nominal_len(input int k);
        return (k < 2) ? 2 : k + 1;
    endfunction

    // Bit index where group k starts
    function automatic int group_lo(input int k);
        int acc = 0;
        for (int i = 0; i < MAX_GROUPS; i++) begin
            if (i < k) acc += nominal_len(i);
        end
        return acc;
    endfunction

    // Number of groups needed to cover w bits
    function automatic int group_count(input int w);
        int n = 0;
        for (int k = 0; k < MAX_GROUPS; k++) begin
            if (group_lo(k) < w) n = k + 1;
        end
        return n;
    endfunction

    // Size of group k, trimmed so the total equals w
    function automatic int group_len(input int w, input int k);
        int lo  = group_lo(k);
        int nom = nominal_len(k);
        return (lo + nom > w) ? (w - lo) : nom;
    endfunction

    function automatic bit width_legal(input int w);
        return (w == 16) || (w == 32) || (w == 64) || (w == 128);
    endfunction

endpackage

// File: rtl/csel_ripple.sv
`timescale 1ns/1ps
module csel_ripple #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         ci,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N:0] chain;

    assign chain[0] = ci;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic half;
        assign half         = a[i] ^ b[i];
        assign s[i]         = half ^ chain[i];
        assign chain[i + 1] = (a[i] & b[i]) | (half & chain[i]);
    end

    assign co = chain[N];
endmodule

// File: rtl/csel_incr.sv
`timescale 1ns/1ps
module csel_incr #(
    parameter int N = 3
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    // flip[i] is high when every bit below i is set; flip[0] is always high
    logic [N-1:0] flip;

    assign flip[0] = 1'b1;
    for (genvar i = 1; i < N; i++) begin : g_and
        assign flip[i] = flip[i - 1] & din[i - 1];
    end

    assign dout = din ^ flip;
endmodule

// File: rtl/csel_pick.sv
`timescale 1ns/1ps
module csel_pick #(
    parameter int N = 3
) (
    input  logic         sel,
    input  logic [N-1:0] d0,
    input  logic [N-1:0] d1,
    output logic [N-1:0] q
);
    assign q = sel ? d1 : d0;
endmodule

// File: rtl/csel_sqrt_adder.sv
`timescale 1ns/1ps
module csel_sqrt_adder
    import csel_sqrt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int NGRP = group_count(WIDTH);

    // Carry leaving each group
    logic [NGRP-1:0] grp_cy;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO  = group_lo(g);
        localparam int LEN = group_len(WIDTH, g);

        if (g == 0) begin : g_base
            csel_ripple #(.N(LEN)) u_rca (
                .a  (op_a[LO +: LEN]),
                .b  (op_b[LO +: LEN]),
                .ci (carry_in),
                .s  (sum_out[LO +: LEN]),
                .co (grp_cy[g])
            );
        end else begin : g_sel
            logic [LEN:0] zero_res;
            logic [LEN:0] inc_res;
            logic [LEN:0] pick_res;

            csel_ripple #(.N(LEN)) u_rca (
                .a  (op_a[LO +: LEN]),
                .b  (op_b[LO +: LEN]),
                .ci (1'b0),
                .s  (zero_res[LEN-1:0]),
                .co (zero_res[LEN])
            );

            csel_incr #(.N(LEN + 1)) u_inc (
                .din  (zero_res),
                .dout (inc_res)
            );

            csel_pick #(.N(LEN + 1)) u_mux (
                .sel (grp_cy[g - 1]),
                .d0  (zero_res),
                .d1  (inc_res),
                .q   (pick_res)
            );

            assign sum_out[LO +: LEN] = pick_res[LEN-1:0];
            assign grp_cy[g]          = pick_res[LEN];
        end
    end

    assign carry_out = grp_cy[NGRP - 1];
endmodule

// File: rtl/csel_sqrt_adder_chk.sv
`timescale 1ns/1ps
module csel_sqrt_adder_chk
    import csel_sqrt_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NGRP  = group_count(WIDTH)
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic [NGRP-1:0]  grp_cy
);
    initial begin
        assert_width_R8: assert (width_legal(WIDTH))
            else $error("R8: unsupported WIDTH %0d", WIDTH);
    end

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

    always_comb begin
        assert_total_R1: assert ({carry_out, sum_out} == ref_total)
            else $error("R1: sum mismatch");
    end

    always_comb begin
        assert_base_R3: assert (grp_cy[0] ==
            ((op_a[1] & op_b[1]) | ((op_a[1] ^ op_b[1]) &
             ((op_a[0] & op_b[0]) | ((op_a[0] ^ op_b[0]) & carry_in)))))
            else $error("R3: base group carry wrong");
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        localparam int LO  = group_lo(g);
        localparam int LEN = group_len(WIDTH, g);
        localparam int HI  = LO + LEN;

        logic [HI:0] part;
        assign part = {1'b0, op_a[HI-1:0]} + {1'b0, op_b[HI-1:0]} + {{HI{1'b0}}, carry_in};

        always_comb begin
            assert_boundary_R6: assert (grp_cy[g] == part[HI])
                else $error("R6: group %0d carry wrong", g);
        end

        if (g > 0) begin : g_upper
            logic [LEN:0] raw;
            assign raw = {1'b0, op_a[LO +: LEN]} + {1'b0, op_b[LO +: LEN]};

            always_comb begin
                if (!grp_cy[g - 1]) begin
                    assert_pass0_R4: assert (sum_out[LO +: LEN] == raw[LEN-1:0])
                        else $error("R4: group %0d zero path wrong", g);
                end else begin
                    assert_pass1_R5: assert (sum_out[LO +: LEN] == raw[LEN-1:0] + LEN'(1))
                        else $error("R5: group %0d increment path wrong", g);
                end
            end
        end
    end
endmodule

bind csel_sqrt_adder csel_sqrt_adder_chk #(.WIDTH(WIDTH), .NGRP(NGRP)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .grp_cy    (grp_cy)
);

// File: tb/tb_csel_sqrt_adder.sv
`timescale 1ns/1ps
module tb_csel_sqrt_adder;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n;
    logic [127:0] a, b;
    logic         ci;

    logic [15:0]  s16;  logic c16;
    logic [31:0]  s32;  logic c32;
    logic [63:0]  s64;  logic c64;
    logic [127:0] s128; logic c128;

    csel_sqrt_adder #(.WIDTH(16)) dut_w16 (
        .op_a(a[15:0]), .op_b(b[15:0]), .carry_in(ci), .sum_out(s16), .carry_out(c16));
    csel_sqrt_adder #(.WIDTH(32)) dut_w32 (
        .op_a(a[31:0]), .op_b(b[31:0]), .carry_in(ci), .sum_out(s32), .carry_out(c32));
    csel_sqrt_adder #(.WIDTH(64)) dut_w64 (
        .op_a(a[63:0]), .op_b(b[63:0]), .carry_in(ci), .sum_out(s64), .carry_out(c64));
    csel_sqrt_adder #(.WIDTH(128)) dut (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s128), .carry_out(c128));

    typedef struct {
        logic [16:0]  e16;
        logic [32:0]  e32;
        logic [64:0]  e64;
        logic [128:0] e128;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;

    task automatic cmp(input string tag, input int w, input logic [128:0] act,
                       input logic [128:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s width %0d: got %h expected %h", tag, w, act, exp);
        end
    endtask

    task automatic drive(input logic [127:0] va, input logic [127:0] vb,
                         input logic vc, input string tag);
        exp_t it;
        @(negedge clk);
        a  = va;
        b  = vb;
        ci = vc;
        it.e16  = {1'b0, va[15:0]}  + {1'b0, vb[15:0]}  + {16'b0, vc};
        it.e32  = {1'b0, va[31:0]}  + {1'b0, vb[31:0]}  + {32'b0, vc};
        it.e64  = {1'b0, va[63:0]}  + {1'b0, vb[63:0]}  + {64'b0, vc};
        it.e128 = {1'b0, va}        + {1'b0, vb}        + {128'b0, vc};
        it.tag  = tag;
        sb.push_back(it);
    endtask

    // Monitor: results settle within the half cycle after each negedge drive
    always @(posedge clk) begin
        exp_t it;
        if (rst_n && sb.size() > 0) begin
            it = sb.pop_front();
            cmp(it.tag, 16,  {112'b0, c16, s16}, {112'b0, it.e16});
            cmp(it.tag, 32,  {96'b0, c32, s32},  {96'b0, it.e32});
            cmp(it.tag, 64,  {64'b0, c64, s64},  {64'b0, it.e64});
            cmp(it.tag, 128, {c128, s128},       it.e128);
        end
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [127:0] ones;
        ones  = '1;
        rst_n = 1'b0;
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: zero plus zero just after reset
        drive('0, '0, 1'b0, "R1 zero");
        // R3: only the lowest group sees carry_in
        drive(128'h3, 128'h0, 1'b1, "R3 base carry");
        drive(128'h1, 128'h1, 1'b1, "R3 base carry");
        drive(128'h2, 128'h1, 1'b0, "R3 base no carry");
        // R7: all ones plus carry-in gives zero with carry out
        drive(ones, '0, 1'b1, "R7 all ones plus one");
        drive(ones, ones, 1'b1, "R7 all ones twice");
        drive('0, ones, 1'b0, "R7 no carry out");
        // R4: no carry anywhere, every group on its zero path
        drive({32{4'h5}}, {32{4'h2}}, 1'b0, "R4 no carries");
        drive({32{4'h5}}, {32{4'ha}}, 1'b0, "R4 alternating");
        // R6: carry-in ripples across every group through the incrementers
        drive({32{4'h5}}, {32{4'ha}}, 1'b1, "R6 full ripple");
        // R5: every group generates and receives a carry
        drive(ones, 128'h1, 1'b0, "R5 generate at bottom");
        drive({64{2'b10}}, {64{2'b10}}, 1'b1, "R5 carry every group");
        // R2 R6: carry chain ending at every bit position, hitting every boundary
        for (int p = 0; p <= 128; p++) begin
            logic [127:0] m;
            m = (p == 0) ? '0 : (ones >> (128 - p));
            drive(m, '0, 1'b1, "R2 R6 chain");
            drive(m, 128'h1, 1'b0, "R2 chain via operand");
        end
        // R1 R8: random vectors at all widths
        for (int i = 0; i < 400; i++) begin
            drive({$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom},
                  1'($urandom), "R1 R8 random");
        end
        // R5: random with one operand mostly ones to force long carries
        for (int i = 0; i < 100; i++) begin
            drive(ones ^ (128'h1 << ($urandom % 128)),
                  {96'b0, $urandom}, 1'($urandom), "R5 long carry");
        end

        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule